// File: doc/BRIEF.md
# Timer Count-Clock Selector

This block decides, once per system clock, whether a 16-bit timer channel should advance. A single free-running prescaler divides the system clock into six square-wave taps at 1/4, 1/16, 1/64, 1/256, 1/1024 and 1/4096 of its rate. A 3-bit select field picks one source for the channel. The source can be the undivided clock, one of the taps, one of four external clock pins, or the overflow/underflow strobe coming from a neighbouring channel. A 2-bit edge field says whether rising transitions, falling transitions or both are counted. The result is a registered count-enable pulse that is one clock wide.

Each instance carries its own table that maps the eight select codes to sources. Channels with different source menus can therefore share the same RTL. Codes that the table marks as unused produce no counts. Three cases override the edge field. The undivided clock counts on every cycle. The cascade strobe counts once per strobe. When phase-counting mode is active on a channel built to support it, the enable output stays low, because the phase decoder drives the counter instead.

Top module: `cnt_clk_sel`

## Requirements
- R1: While `rst` is high, `cnt_en` is 0, and the prescaler and all edge history restart from zero.
- R2: With `edge_mode` = 00, a divided tap of ratio D gives exactly W/D pulses in any window of W cycles, where W is a multiple of D. An external pin gives one pulse per rising transition.
- R3: With `edge_mode` = 01, only falling transitions are counted. A rising transition on an external pin produces no pulse, and each falling transition produces one.
- R4: With `edge_mode` = 10 or 11, both transitions are counted, which gives twice the count of single-edge operation for taps and pins alike.
- R5: When the selected source is the undivided clock, `cnt_en` is 1 on every cycle whatever the value of `edge_mode`.
- R6: When the cascade source is selected, each `casc_stb` cycle produces exactly one pulse in the following cycle, whatever the value of `edge_mode`.
- R7: On an instance with PHASE_CAPABLE=1, `phase_mode`=1 holds `cnt_en` at 0. On an instance with PHASE_CAPABLE=0, `phase_mode` has no effect.
- R8: A select code whose table entry is not a defined source (entry value above 11) never raises `cnt_en`.
- R9: Table entries use these IDs: 0 for the undivided clock, k=1..6 for the tap at ratio 4^k, 7 to 10 for external pins 0 to 3, and 11 for cascade. The default table for codes 7..0 is 11,6,9,7,3,2,1,0.
- R10: For every source except the undivided clock, `cnt_en` is never high on two consecutive cycles, provided the external pins hold each level for at least two cycles.
- R11: A level change on an external pin that is applied before clock edge n raises `cnt_en` after edge n+2 for exactly one cycle, when that edge is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_code | input | 3 | Count-source select code, decoded through SEL_MAP |
| edge_mode | input | 2 | 00 rising, 01 falling, 1x both |
| phase_mode | input | 1 | Phase-counting mode active for this channel |
| ext_clk | input | 4 | Asynchronous external clock pins |
| casc_stb | input | 1 | One-cycle overflow/underflow strobe from another channel |
| cnt_en | output | 1 | One-cycle count-enable for the timer counter |

## Verification
The pulse-spacing assertions on taps and pins assume that each external pin holds its level for at least two system clocks. A pin that changes faster could produce a transition in back-to-back cycles. The bench drives every pin with a square wave of period 8 cycles, and pulses the cascade strobe no more often than every 8 cycles. The cascade check assumes the strobe is a single-cycle pulse. Select and edge fields change only between measurement windows, and each window starts after a settling gap.

// File: rtl/cnt_clk_sel_pkg.sv
package cnt_clk_sel_pkg;

  // Edge-mode decode: bit 1 set means both transitions, else bit 0 picks falling.
  function automatic logic edge_pick(input logic [1:0] mode, input logic rise, input logic fall);
    if (mode[1])
      return rise | fall;
    else if (mode[0])
      return fall;
    else
      return rise;
  endfunction

endpackage

// File: rtl/cnt_clk_presc.sv
module cnt_clk_presc #(
  parameter int TAP_COUNT = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [TAP_COUNT-2:0] tap_rise,
  output logic [TAP_COUNT-2:0] tap_fall
);
  localparam int CW = 2 * (TAP_COUNT - 1);

  logic [CW-1:0]        div_cnt;
  logic [TAP_COUNT-2:0] wave;
  logic [TAP_COUNT-2:0] wave_q;

  always_ff @(posedge clk) begin
    if (rst) div_cnt <= '0;
    else     div_cnt <= div_cnt + 1'b1;
  end

  // Tap k+1 divides by 4^(k+1): its square wave is counter bit 2k+1.
  for (genvar k = 0; k < TAP_COUNT - 1; k++) begin : g_tap
    assign wave[k] = div_cnt[2*k+1];

    AST_TAP_RISE_SPACED: assert property (@(posedge clk) disable iff (rst)
      tap_rise[k] |=> !tap_rise[k]); // R10
    AST_TAP_FALL_SPACED: assert property (@(posedge clk) disable iff (rst)
      tap_fall[k] |=> !tap_fall[k]); // R10
  end

  always_ff @(posedge clk) begin
    if (rst) wave_q <= '0;
    else     wave_q <= wave;
  end

  assign tap_rise = wave & ~wave_q;
  assign tap_fall = ~wave & wave_q;

endmodule

// File: rtl/cnt_clk_ext_edge.sv
module cnt_clk_ext_edge #(
  parameter int PINS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pin_async,
  output logic [PINS-1:0] pin_rise,
  output logic [PINS-1:0] pin_fall
);
  logic [PINS-1:0] sync_a;
  logic [PINS-1:0] sync_b;
  logic [PINS-1:0] sync_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a    <= '0;
      sync_b    <= '0;
      sync_prev <= '0;
    end else begin
      sync_a    <= pin_async;
      sync_b    <= sync_a;
      sync_prev <= sync_b;
    end
  end

  assign pin_rise = sync_b & ~sync_prev;
  assign pin_fall = ~sync_b & sync_prev;

  for (genvar p = 0; p < PINS; p++) begin : g_pin_chk
    AST_PIN_EDGE_SPACED: assert property (@(posedge clk) disable iff (rst)
      (pin_rise[p] | pin_fall[p]) |=> !(pin_rise[p] | pin_fall[p])); // R10
  end

endmodule

// File: rtl/cnt_clk_sel.sv
module cnt_clk_sel
  import cnt_clk_sel_pkg::*;
#(
  parameter int TAP_COUNT = 7,
  parameter int EXT_PINS  = 4,
  parameter int SEL_W     = 3,
  parameter int ID_W      = 4,
  parameter logic [(2**SEL_W)*ID_W-1:0] SEL_MAP = 32'hB697_3210,
  parameter bit PHASE_CAPABLE = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    src_code,
  input  logic [1:0]          edge_mode,
  input  logic                phase_mode,
  input  logic [EXT_PINS-1:0] ext_clk,
  input  logic                casc_stb,
  output logic                cnt_en
);
  localparam int ID_EXT0 = TAP_COUNT;
  localparam int ID_CASC = TAP_COUNT + EXT_PINS;

  logic [TAP_COUNT-2:0] tap_rise, tap_fall;
  logic [EXT_PINS-1:0]  pin_rise, pin_fall;
  logic [ID_W-1:0]      src_id;
  logic                 sel_rise, sel_fall, pulse, phase_gate;

  cnt_clk_presc #(.TAP_COUNT(TAP_COUNT)) presc_i (
    .clk(clk), .rst(rst), .tap_rise(tap_rise), .tap_fall(tap_fall));

  cnt_clk_ext_edge #(.PINS(EXT_PINS)) ext_i (
    .clk(clk), .rst(rst), .pin_async(ext_clk), .pin_rise(pin_rise), .pin_fall(pin_fall));

  assign src_id     = SEL_MAP[int'(src_code)*ID_W +: ID_W];
  assign phase_gate = phase_mode & PHASE_CAPABLE;

  always_comb begin
    sel_rise = 1'b0;
    sel_fall = 1'b0;
    for (int k = 1; k < TAP_COUNT; k++) begin
      if (src_id == ID_W'(k)) begin
        sel_rise = tap_rise[k-1];
        sel_fall = tap_fall[k-1];
      end
    end
    for (int e = 0; e < EXT_PINS; e++) begin
      if (src_id == ID_W'(ID_EXT0 + e)) begin
        sel_rise = pin_rise[e];
        sel_fall = pin_fall[e];
      end
    end
    if (src_id == '0)
      pulse = 1'b1;
    else if (src_id == ID_W'(ID_CASC))
      pulse = casc_stb;
    else
      pulse = edge_pick(edge_mode, sel_rise, sel_fall);
    if (phase_gate)
      pulse = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_en <= 1'b0;
    else     cnt_en <= pulse;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !cnt_en); // R1
  AST_DIV1_EVERY: assert property (@(posedge clk) disable iff (rst)
    (src_id == '0 && !phase_gate) |=> cnt_en); // R5
  AST_CASCADE_PASS: assert property (@(posedge clk) disable iff (rst)
    (src_id == ID_W'(ID_CASC) && casc_stb && !phase_gate) |=> cnt_en); // R6
  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (rst)
    (int'(src_id) > ID_CASC) |=> !cnt_en); // R8

  if (PHASE_CAPABLE) begin : g_phase_chk
    AST_PHASE_SILENCE: assert property (@(posedge clk) disable iff (rst)
      phase_mode |=> !cnt_en); // R7
  end

endmodule

// File: tb/cnt_clk_sel_tb_top.sv
module cnt_clk_sel_tb_top;
  localparam int WIN = 4096;
  localparam int EXT_HALF = 4;
  localparam int CASC_PER = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] src_code = 3'd0;
  logic [1:0] edge_mode = 2'b00;
  logic       phase_mode = 1'b0;
  logic [3:0] ext_tog = 4'h0;
  logic [3:0] ext_man = 4'h0;
  logic       ext_run = 1'b0;
  logic       casc_stb = 1'b0;
  logic       casc_run = 1'b0;
  logic [3:0] ext_clk;
  logic       cnt_en_a, cnt_en_b;

  int tests = 0;
  int fails = 0;
  int maxrun_a = 0;
  int maxrun_b = 0;

  assign ext_clk = ext_run ? ext_tog : ext_man;

  always #2 clk = ~clk;

  cnt_clk_sel dut_i (
    .clk(clk), .rst(rst), .src_code(src_code), .edge_mode(edge_mode),
    .phase_mode(phase_mode), .ext_clk(ext_clk), .casc_stb(casc_stb), .cnt_en(cnt_en_a));

  cnt_clk_sel #(.SEL_MAP(32'hFA54_3210), .PHASE_CAPABLE(1'b0)) dut_b_i (
    .clk(clk), .rst(rst), .src_code(src_code), .edge_mode(edge_mode),
    .phase_mode(phase_mode), .ext_clk(ext_clk), .casc_stb(casc_stb), .cnt_en(cnt_en_b));

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph++;
      if (ph == EXT_HALF) begin
        ph = 0;
        ext_tog = ~ext_tog;
      end
    end
  end

  initial begin
    int cc = 0;
    forever begin
      @(negedge clk);
      cc++;
      casc_stb = casc_run && (cc % CASC_PER == 0);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic measure(input int n, input bit track, output int ca, output int cb);
    int run_a = 0;
    int run_b = 0;
    ca = 0;
    cb = 0;
    repeat (4) @(posedge clk);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      ca += int'(cnt_en_a);
      cb += int'(cnt_en_b);
      run_a = cnt_en_a ? run_a + 1 : 0;
      run_b = cnt_en_b ? run_b + 1 : 0;
      if (track && run_a > maxrun_a) maxrun_a = run_a;
      if (track && run_b > maxrun_b) maxrun_b = run_b;
    end
  endtask

  // Expected count from the R9 table; kind: 0 div1, 1 tap/pin, 2 cascade, 3 none.
  function automatic int expect_cnt(input bit is_b, input int src, input int em, output int kind);
    int mult = (em >= 2) ? 2 : 1;
    int id_a[8] = '{0, 1, 2, 3, 7, 9, 6, 11};
    int id_b[8] = '{0, 1, 2, 3, 4, 5, 10, 15};
    int id = is_b ? id_b[src] : id_a[src];
    kind = 1;
    if (id == 0) begin kind = 0; return WIN; end
    if (id <= 6) return (WIN >> (2*id)) * mult;
    if (id <= 10) return (WIN / (2*EXT_HALF)) * mult;
    if (id == 11) begin kind = 2; return WIN / CASC_PER; end
    kind = 3;
    return 0;
  endfunction

  function automatic string tag_of(input int kind, input int em);
    if (kind == 0) return "R5";
    if (kind == 2) return "R6";
    if (kind == 3) return "R8";
    if (em == 0) return "R2 R9";
    if (em == 1) return "R3 R9";
    return "R4 R9";
  endfunction

  task automatic t_reset();
    int hi = 0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk);
      #1;
      hi += int'(cnt_en_a) + int'(cnt_en_b);
    end
    check("R1", "enable during reset", hi, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_edge_sweep(input int em);
    int ca, cb, ka, kb;
    ext_run  = 1'b1;
    casc_run = 1'b1;
    for (int s = 0; s < 8; s++) begin
      int ea, eb;
      @(negedge clk);
      src_code  = 3'(s);
      edge_mode = 2'(em);
      measure(WIN, s != 0, ca, cb);
      ea = expect_cnt(1'b0, s, em, ka);
      eb = expect_cnt(1'b1, s, em, kb);
      check(tag_of(ka, em), $sformatf("inst A code %0d edge %0d", s, em), ca, ea);
      check(tag_of(kb, em), $sformatf("inst B code %0d edge %0d", s, em), cb, eb);
    end
  endtask

  task automatic t_phase();
    int ca, cb;
    @(negedge clk);
    src_code   = 3'd1;
    edge_mode  = 2'b00;
    phase_mode = 1'b1;
    measure(WIN, 1'b1, ca, cb);
    check("R7", "phase mode, capable instance", ca, 0);
    check("R7", "phase mode, non-capable instance", cb, WIN / 4);
    @(negedge clk);
    phase_mode = 1'b0;
  endtask

  task automatic t_ext_latency();
    int ca, cb;
    @(negedge clk);
    ext_run   = 1'b0;
    casc_run  = 1'b0;
    ext_man   = 4'h0;
    src_code  = 3'd4;
    edge_mode = 2'b00;
    repeat (6) @(negedge clk);
    ext_man[0] = 1'b1;
    repeat (2) @(posedge clk);
    #1 check("R11", "no pulse before third edge", int'(cnt_en_a), 0);
    @(posedge clk);
    #1 check("R11", "rising pulse after third edge", int'(cnt_en_a), 1);
    @(posedge clk);
    #1 check("R11", "pulse lasts one cycle", int'(cnt_en_a), 0);
    @(negedge clk);
    ext_man[0] = 1'b0;
    measure(6, 1'b1, ca, cb);
    check("R2", "falling pin ignored in rising mode", ca, 0);
    @(negedge clk);
    edge_mode = 2'b01;
    ext_man[0] = 1'b1;
    measure(6, 1'b1, ca, cb);
    check("R3", "rising pin ignored in falling mode", ca, 0);
    @(negedge clk);
    ext_man[0] = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R3", "falling pulse after third edge", int'(cnt_en_a), 1);
  endtask

  task automatic t_pulse_width();
    check("R10", "longest enable run, instance A", maxrun_a, 1);
    check("R10", "longest enable run, instance B", maxrun_b, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    for (int em = 0; em < 4; em++) t_edge_sweep(em);
    t_phase();
    t_ext_latency();
    t_pulse_width();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule